// File: doc/BRIEF.md
# Four-Phase Instruction Fetch Sequencer

This block is the front end of a small microcontroller core. It splits the input clock into instruction cycles of four phases each. In every instruction cycle it reads one 16-bit word from a byte-addressed program memory while the word fetched in the previous cycle executes. At the start of each instruction cycle it loads the fetched word into an instruction register and moves the program counter to the next word.

The sequencer recognises absolute jumps and the head words of two-word instructions. It also accepts a taken-branch request with a signed word offset from the datapath. When the program counter is redirected, the word that was already prefetched is kept in the instruction register but flagged as a forced no-op. A redirected instruction therefore costs two instruction cycles.

The block drives an operand-read strobe and a result-write strobe for the datapath. It also flags which execute cycles are real, which are the second half of a two-word instruction, and which are absolute jumps.

Top module: `fetch_seq_core`

## Requirements
- R1: The `phase` output is one-hot and steps through Q1 (bit 0), Q2 (bit 1), Q3 (bit 2) and Q4 (bit 3), returning to Q1 after Q4. One instruction cycle lasts four clocks.
- R2: On the clock edge that begins Q1, the instruction register loads the word on `pmem_rdata`. On the same edge, the program counter advances by 2 unless a redirect applies. While one word executes, the next word is fetched.
- R3: `pmem_addr` is a byte address whose bit 0 is always 0. It changes only at the start of Q1.
- R4: `rd_stb` is high only during Q2 and `wr_stb` only during Q4. Both stay low in execute cycles flagged `ex_nop`.
- R5: An executing word whose high byte is EFh is an absolute jump, and `ex_jump` is high during its execute cycle. The second word, fetched during that cycle, supplies target word bits 19:8 in its bits 11:0. The first word supplies target word bits 7:0 in its bits 7:0. This word address is written to PC bits 20:1.
- R6: If `br_taken` is high at the end of Q4 of a non-no-op execute cycle, the next fetch address is the current fetch address plus twice the signed `br_offset`.
- R7: After any redirect (an absolute jump or a taken branch), the next execute cycle has `ex_nop` high. Its word stays visible in `ir_word`.
- R8: An executing word with high nibble Ch is the head of a two-word instruction. The following execute cycle carries its second word with `ex_second` high and `ex_nop` low.
- R9: A word with high nibble Fh that reaches execution without a pending two-word head executes with `ex_nop` high.
- R10: `br_taken` has no effect on the program counter during an `ex_nop` cycle or during an absolute-jump cycle.
- R11: While reset is asserted, `pmem_addr` is 0, `phase` is Q1, `ir_word` is 0000h, `ex_nop` is 1, and `ex_second` and `ex_jump` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, four per instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pmem_addr | output | PC_W | Byte address of the word being fetched |
| pmem_rdata | input | 16 | Word read at `pmem_addr`, assembled little-endian |
| br_taken | input | 1 | Datapath request for a relative branch |
| br_offset | input | OFF_W | Signed branch offset in words |
| phase | output | 4 | One-hot phase, bit 0 is Q1 |
| ir_word | output | 16 | Instruction register |
| ex_nop | output | 1 | Current execute cycle is a forced no-op |
| ex_second | output | 1 | Current word is the second half of a two-word instruction |
| ex_jump | output | 1 | Current word is an executing absolute jump |
| rd_stb | output | 1 | Operand-read strobe in Q2 |
| wr_stb | output | 1 | Result-write strobe in Q4 |

## Verification
Assertions check on every cycle that:
- the phase counter wraps from Q4 to Q1;
- the program counter and instruction register hold steady between cycle boundaries;
- an unredirected cycle advances the fetch address by exactly 2;
- every redirect is followed by a flagged no-op;
- the strobes are single-clock pulses.

Only the bench's scenarios can show that the decoded jump target, branch arithmetic and two-word pairing produce the right addresses and words. The same holds for orphan tail words becoming no-ops, for branch requests being ignored in flushed cycles, and for the reset values.

// File: rtl/seq_pkg.sv
package seq_pkg;
   localparam int WORD_W     = 16;
   localparam int JMP_TGT_W  = 20;
   localparam logic [WORD_W-1:0] NOP_WORD = 16'h0000;

   function automatic logic is_abs_jump(input logic [WORD_W-1:0] w);
      return w[15:8] == 8'hEF;
   endfunction

   function automatic logic is_pair_head(input logic [WORD_W-1:0] w);
      return w[15:12] == 4'hC;
   endfunction

   function automatic logic is_tail_word(input logic [WORD_W-1:0] w);
      return w[15:12] == 4'hF;
   endfunction

   function automatic logic [JMP_TGT_W-1:0] jump_target(input logic [WORD_W-1:0] head,
                                                        input logic [WORD_W-1:0] tail);
      return {tail[11:0], head[7:0]};
   endfunction
endpackage

// File: rtl/seq_phase_gen.sv
module seq_phase_gen #(
   parameter int PHASES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [PHASES-1:0] ph_onehot,
   output logic              cyc_end
);
   localparam int CNT_W = $clog2(PHASES);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASES - 1);

   if (PHASES != 4) begin : g_bad_phases
      $error("seq_phase_gen: phase roles require exactly four phases");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   for (genvar i = 0; i < PHASES; i++) begin : g_dec
      assign ph_onehot[i] = (cnt == CNT_W'(i));
   end

   assign cyc_end = (cnt == LAST);

   // R1
   phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LAST) |=> (cnt == '0));
   // R1
   phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit
   import seq_pkg::*;
#(
   parameter int PC_W  = 21,
   parameter int OFF_W = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   input  logic                 jump_en,
   input  logic [JMP_TGT_W-1:0] jump_word,
   input  logic                 br_en,
   input  logic [OFF_W-1:0]     br_off,
   output logic [PC_W-1:0]      pc_byte
);
   localparam int WA_W = PC_W - 1;

   if (PC_W < 9 || PC_W > 32) begin : g_bad_pcw
      $error("seq_pc_unit: PC_W out of range");
   end
   if (OFF_W < 2 || OFF_W > WA_W) begin : g_bad_offw
      $error("seq_pc_unit: OFF_W must fit the word address");
   end

   logic [WA_W-1:0] pc_w;
   logic [WA_W-1:0] tgt_w;
   logic [WA_W-1:0] disp_w;
   logic [WA_W-1:0] pc_nxt;

   // Absolute target width adaptation
   if (WA_W == JMP_TGT_W) begin : g_tgt_eq
      assign tgt_w = jump_word;
   end else if (WA_W > JMP_TGT_W) begin : g_tgt_ext
      assign tgt_w = {{(WA_W-JMP_TGT_W){1'b0}}, jump_word};
   end else begin : g_tgt_trunc
      assign tgt_w = jump_word[WA_W-1:0];
   end

   // Relative displacement sign extension
   if (OFF_W == WA_W) begin : g_off_eq
      assign disp_w = br_off;
   end else begin : g_off_sext
      assign disp_w = {{(WA_W-OFF_W){br_off[OFF_W-1]}}, br_off};
   end

   always_comb begin
      if (jump_en)    pc_nxt = tgt_w;
      else if (br_en) pc_nxt = pc_w + disp_w;
      else            pc_nxt = pc_w + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   pc_w <= '0;
      else if (adv) pc_w <= pc_nxt;
   end

   assign pc_byte = {pc_w, 1'b0};

   // R3
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(pc_w));
endmodule

// File: rtl/seq_ir_stage.sv
module seq_ir_stage
   import seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              flush,
   input  logic [WORD_W-1:0] fetch_word,
   output logic [WORD_W-1:0] ir,
   output logic              nop,
   output logic              second
);
   logic pend_nxt;
   logic nop_nxt;

   always_comb begin
      pend_nxt = !nop && !second && is_pair_head(ir) && !flush;
      nop_nxt  = flush || (is_tail_word(fetch_word) && !pend_nxt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ir     <= NOP_WORD;
         nop    <= 1'b1;
         second <= 1'b0;
      end else if (load) begin
         ir     <= fetch_word;
         nop    <= nop_nxt;
         second <= pend_nxt;
      end
   end

   // R2
   ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(ir));
   // R8
   second_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      second |-> !nop);
endmodule

// File: rtl/fetch_seq_core.sv
module fetch_seq_core
   import seq_pkg::*;
#(
   parameter int PC_W  = 21,
   parameter int OFF_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [PC_W-1:0]   pmem_addr,
   input  logic [15:0]       pmem_rdata,
   input  logic              br_taken,
   input  logic [OFF_W-1:0]  br_offset,
   output logic [3:0]        phase,
   output logic [15:0]       ir_word,
   output logic              ex_nop,
   output logic              ex_second,
   output logic              ex_jump,
   output logic              rd_stb,
   output logic              wr_stb
);
   localparam int PHASES = 4;

   logic                 cyc_end;
   logic                 jump_en;
   logic                 br_en;
   logic                 redirect;
   logic [JMP_TGT_W-1:0] jump_word;

   seq_phase_gen #(.PHASES(PHASES)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .ph_onehot (phase),
      .cyc_end   (cyc_end)
   );

   always_comb begin
      jump_en   = !ex_nop && is_abs_jump(ir_word);
      br_en     = !ex_nop && !jump_en && br_taken;
      redirect  = jump_en || br_en;
      jump_word = jump_target(ir_word, pmem_rdata);
   end

   seq_pc_unit #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv       (cyc_end),
      .jump_en   (jump_en),
      .jump_word (jump_word),
      .br_en     (br_en),
      .br_off    (br_offset),
      .pc_byte   (pmem_addr)
   );

   seq_ir_stage u_ir (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cyc_end),
      .flush      (redirect),
      .fetch_word (pmem_rdata),
      .ir         (ir_word),
      .nop        (ex_nop),
      .second     (ex_second)
   );

   assign ex_jump = jump_en;
   assign rd_stb  = phase[1] && !ex_nop;
   assign wr_stb  = phase[3] && !ex_nop;

   // R7
   flush_after_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_end && redirect) |=> ex_nop);
   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_end && !redirect) |=> (pmem_addr == $past(pmem_addr) + PC_W'(2)));
   // R4
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> !rd_stb);
   // R4
   wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);
endmodule

// File: tb/tb_fetch_seq_core.sv
module tb_fetch_seq_core;
   localparam int PC_W  = 21;
   localparam int OFF_W = 11;
   localparam int NROW  = 17;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [PC_W-1:0]   pmem_addr;
   logic [15:0]       pmem_rdata;
   logic              br_taken = 1'b0;
   logic [OFF_W-1:0]  br_offset = '0;
   logic [3:0]        phase;
   logic [15:0]       ir_word;
   logic              ex_nop, ex_second, ex_jump, rd_stb, wr_stb;

   logic [15:0] mem [64];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   assign pmem_rdata = mem[pmem_addr[6:1]];

   fetch_seq_core #(.PC_W(PC_W), .OFF_W(OFF_W)) dut (
      .clk(clk), .rst_n(rst_n), .pmem_addr(pmem_addr), .pmem_rdata(pmem_rdata),
      .br_taken(br_taken), .br_offset(br_offset), .phase(phase), .ir_word(ir_word),
      .ex_nop(ex_nop), .ex_second(ex_second), .ex_jump(ex_jump),
      .rd_stb(rd_stb), .wr_stb(wr_stb)
   );

   // {ir, nop, second, jump, fetch byte addr, br_taken, br_offset}
   localparam logic [38:0] VEC [NROW] = '{
      {16'h0000, 3'b100, 8'h00, 1'b0, 11'd0},
      {16'h0E55, 3'b000, 8'h02, 1'b0, 11'd0},
      {16'hC123, 3'b000, 8'h04, 1'b0, 11'd0},
      {16'hF456, 3'b010, 8'h06, 1'b0, 11'd0},
      {16'hEF08, 3'b001, 8'h08, 1'b1, 11'd1},
      {16'hF000, 3'b100, 8'h10, 1'b1, 11'd5},
      {16'h2222, 3'b000, 8'h12, 1'b0, 11'd0},
      {16'h3333, 3'b000, 8'h14, 1'b1, 11'd3},
      {16'h4444, 3'b100, 8'h1A, 1'b0, 11'd0},
      {16'hF999, 3'b100, 8'h1C, 1'b1, 11'd2},
      {16'h5555, 3'b000, 8'h1E, 1'b0, 11'd0},
      {16'h3334, 3'b000, 8'h20, 1'b1, 11'h7F2},
      {16'h6666, 3'b100, 8'h04, 1'b0, 11'd0},
      {16'hF456, 3'b100, 8'h06, 1'b0, 11'd0},
      {16'hEF08, 3'b001, 8'h08, 1'b0, 11'd0},
      {16'hF000, 3'b100, 8'h10, 1'b0, 11'd0},
      {16'h2222, 3'b000, 8'h12, 1'b0, 11'd0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic next_phase();
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
      mem[0] = 16'h0E55; mem[1] = 16'hC123; mem[2] = 16'hF456; mem[3] = 16'hEF08;
      mem[4] = 16'hF000; mem[5] = 16'h1111; mem[8] = 16'h2222; mem[9] = 16'h3333;
      mem[10] = 16'h4444; mem[13] = 16'hF999; mem[14] = 16'h5555; mem[15] = 16'h3334;
      mem[16] = 16'h6666;

      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 pc", 32'(pmem_addr), 32'h0);
      chk("R11 phase", 32'(phase), 32'h1);
      chk("R11 ir", 32'(ir_word), 32'h0);
      chk("R11 nop", 32'(ex_nop), 32'h1);
      chk("R11 second/jump", {ex_second, ex_jump}, 32'h0);
      rst_n = 1'b1;

      // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
      for (int r = 0; r < NROW; r++) begin
         logic [38:0] v;
         v = VEC[r];
         chk("R1 phase Q1", 32'(phase), 32'h1);
         chk("R2 ir", 32'(ir_word), 32'(v[38:23]));
         chk("R7/R9 nop", 32'(ex_nop), 32'(v[22]));
         chk("R8 second", 32'(ex_second), 32'(v[21]));
         chk("R5 jump", 32'(ex_jump), 32'(v[20]));
         chk("R6/R10 fetch addr", 32'(pmem_addr), 32'(v[19:12]));
         chk("R4 rd in Q1", 32'(rd_stb), 32'h0);
         br_taken  = v[11];
         br_offset = v[10:0];
         next_phase();
         chk("R1 phase Q2", 32'(phase), 32'h2);
         chk("R4 rd in Q2", 32'(rd_stb), 32'(!v[22]));
         next_phase();
         chk("R3 addr held Q3", 32'(pmem_addr), 32'(v[19:12]));
         next_phase();
         chk("R4 wr in Q4", 32'(wr_stb), 32'(!v[22]));
         next_phase();
         br_taken = 1'b0;
      end

      // R5: absolute target in upper PC bits
      rst_n = 1'b0;
      mem[0] = 16'hEF34;
      mem[1] = 16'hF012;
      repeat (2) @(negedge clk);
      chk("R11 reset again pc", 32'(pmem_addr), 32'h0);
      chk("R11 reset again phase", 32'(phase), 32'h1);
      rst_n = 1'b1;
      repeat (4) next_phase();
      chk("R5 jump flag", 32'(ex_jump), 32'h1);
      chk("R5 ir", 32'(ir_word), 32'hEF34);
      repeat (4) next_phase();
      chk("R5 target byte addr", 32'(pmem_addr), 32'h02468);
      chk("R3 bit0 zero", 32'(pmem_addr[0]), 32'h0);
      chk("R7 nop after jump", 32'(ex_nop), 32'h1);
      chk("R7 discarded word visible", 32'(ir_word), 32'hF012);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule